// File: doc/BRIEF.md
# Inter-thread FIFO storage cell

This block is one shared storage cell through which several hardware threads pass 64-bit words. A requester sends a single access per cycle. Address bits [6:3] carry a view code, and that code chooses how the cell treats the access. The cell holds a circular queue with a power-of-two depth. It also holds a tag word made of an empty flag (E), a full flag (F), a software trigger bit (T), a FIFO-mode flag that always reads as 1, an element count and a depth exponent.

Through the empty/full views the cell acts as a queue. The try form of these views never waits. The blocking form returns a one-cycle stall flag when it cannot proceed, together with the requester's ID, and records that ID in a parked-thread mask. The next empty/full access that does go ahead pulses a wake vector that holds the whole mask, and then clears the mask. The bypass view reads and patches data without moving the queue. The control view reads and writes the tag. The semaphore views and the unused codes are inert for this cell.

Every response, stall flag and wake pulse is registered. Each appears on the cycle after the access.

Top module: `ithread_fifo_cell`

## Requirements
- R1: The view code is req_addr[6:3]: 0 bypass, 1 control, 2 empty/full blocking, 3 empty/full try, 4 and 5 semaphore blocking/try, 6..15 unused. rsp_valid, rsp_rdata, rsp_stall and wake_vec reflect an access on the following cycle.
- R2: After reset the control view reads E=1, F=0, T=0, FIFO=1, count 0 and depth field log2(DEPTH), and wake_vec is zero.
- R3: An empty/full write that does not stall clears E. If the count is below DEPTH it stores the data at (head + count) mod DEPTH and increments the count, otherwise the data is dropped. F is set once the count equals DEPTH.
- R4: An empty/full read that does not stall clears F. If the count is non-zero it returns the head element, advances the head and decrements the count, otherwise it returns 0. E is set once the count is zero.
- R5: A blocking empty/full read while E=1 stalls. It sets rsp_stall, returns 0, ORs bit req_id into the parked mask, clears F, and leaves the queue unchanged.
- R6: A blocking empty/full write while F=1 stalls. It presents req_id on rsp_stall_id, parks the requester, clears E, and stores nothing.
- R7: An empty/full access that does not stall drives wake_vec with the parked mask for exactly one cycle and clears the mask. A stalled access never wakes.
- R8: A bypass read returns the head element and does not pop it. A bypass write overwrites the most recently pushed element, and only while the count is non-zero.
- R9: A control write loads T, E and F from data bits 16, 0 and 1. If the written E bit is 1, the count is set to zero and the head position is kept.
- R10: The control read word places the depth exponent at bits 31:28, the count at 27:18, FIFO=1 at 17, T at 16, F at 1 and E at 0. All other bits are zero.
- R11: Semaphore-view accesses return 0 and unused view codes return all ones. Neither changes the queue, the flags or the parked mask.
- R12: Head and tail positions wrap modulo DEPTH, so data keeps FIFO order across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address, view code in bits [6:3] |
| req_wdata | input | DW | Write data |
| req_id | input | IDW | Requester (thread) ID |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | DW | Read data, 0 for writes |
| rsp_stall | output | 1 | Previous access was parked |
| rsp_stall_id | output | IDW | ID of the parked requester |
| wake_vec | output | NREQ | One-cycle release pulse, one bit per requester |

## Verification
Two outcomes can land on the same registered cycle: a release pulse, and a queue movement (a pop that frees a full queue, or a push that is dropped because the queue is full). The bench provokes this by filling the queue and parking a writer with a blocking write. It then issues a try-write, which must wake the writer and drop its data. Next it parks a second writer and issues a try-read. That response must carry both the oldest element and the wake bit for the parked ID. The control view must then show F cleared and the count reduced by one. Draining the queue afterwards confirms that the dropped word never entered it.

// File: rtl/ithread_fifo_cell.sv
module ithread_fifo_cell #(
  parameter int DEPTH = 8,
  parameter int DW    = 64,
  parameter int NREQ  = 8,
  parameter int AW    = 12,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1,
  localparam int IDW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [IDW-1:0]  req_id,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_stall,
  output logic [IDW-1:0]  rsp_stall_id,
  output logic [NREQ-1:0] wake_vec
);

  logic [DW-1:0]   mem [DEPTH];
  logic [PW-1:0]   head;
  logic [CW-1:0]   count;
  logic            tag_e, tag_f, tag_t;
  logic [NREQ-1:0] parked;

  wire [3:0]    view     = req_addr[6:3];
  wire          is_ef    = (view == 4'd2) || (view == 4'd3);
  wire          blocking = (view == 4'd2);
  wire          stall    = req_valid && is_ef && blocking &&
                           (req_write ? tag_f : tag_e);
  wire          ef_go    = req_valid && is_ef && !stall;
  wire          do_pop   = ef_go && !req_write && (count != '0);
  wire          do_push  = ef_go && req_write && (count < CW'(DEPTH));
  wire [PW-1:0] tail     = head + count[PW-1:0];
  wire [PW-1:0] newest   = tail - PW'(1);
  wire [NREQ-1:0] id_bit = NREQ'(1) << req_id;

  logic [DW-1:0] ctl_word, rd_val;
  always_comb begin
    ctl_word        = '0;
    ctl_word[31:28] = 4'(PW);
    ctl_word[27:18] = 10'(count);
    ctl_word[17]    = 1'b1;
    ctl_word[16]    = tag_t;
    ctl_word[1]     = tag_f;
    ctl_word[0]     = tag_e;
    rd_val = '0;
    if (!req_write) begin
      case (view)
        4'd0:         rd_val = mem[head];
        4'd1:         rd_val = ctl_word;
        4'd2, 4'd3:   rd_val = do_pop ? mem[head] : '0;
        4'd4, 4'd5:   rd_val = '0;
        default:      rd_val = '1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[tail] <= req_wdata;
    else if (req_valid && req_write && view == 4'd0 && count != '0)
      mem[newest] <= req_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0; count <= '0;
      tag_e <= 1'b1; tag_f <= 1'b0; tag_t <= 1'b0;
      parked <= '0; wake_vec <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0; rsp_stall <= 1'b0; rsp_stall_id <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_rdata    <= req_valid ? rd_val : '0;
      rsp_stall    <= stall;
      rsp_stall_id <= stall ? req_id : '0;
      wake_vec     <= '0;
      if (req_valid && view == 4'd1 && req_write) begin
        tag_t <= req_wdata[16];
        tag_e <= req_wdata[0];
        tag_f <= req_wdata[1];
        if (req_wdata[0]) count <= '0;
      end
      if (req_valid && is_ef) begin
        if (req_write) tag_e <= 1'b0;
        else           tag_f <= 1'b0;
        if (stall) parked <= parked | id_bit;
        else begin
          wake_vec <= parked;
          parked   <= '0;
          if (req_write) begin
            if (do_push) count <= count + CW'(1);
            tag_f <= (count >= CW'(DEPTH - 1));
          end else begin
            if (do_pop) begin
              head  <= head + PW'(1);
              count <= count - CW'(1);
            end
            tag_e <= (count <= CW'(1));
          end
        end
      end
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_empty_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && count == CW'(1)) |=> tag_e);
  p_stall_no_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_stall |-> (wake_vec == '0));
  p_stall_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && rsp_valid == rsp_valid) |=> (rsp_stall && rsp_stall_id == $past(req_id)));
  p_wake_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_vec != '0) |=> (wake_vec == '0));
  p_pv_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (view == 4'd4 || view == 4'd5)) |=>
      ($stable(count) && $stable(head) && $stable(parked)));

endmodule

// File: tb/ithread_fifo_cell_tb.sv
module ithread_fifo_cell_tb;
  localparam int DW = 64, NREQ = 8, AW = 12, IDW = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [IDW-1:0] req_id = '0;
  logic rsp_valid, rsp_stall;
  logic [DW-1:0] rsp_rdata;
  logic [IDW-1:0] rsp_stall_id;
  logic [NREQ-1:0] wake_vec;

  always #2 clk = ~clk;

  ithread_fifo_cell #(.DEPTH(8), .DW(DW), .NREQ(NREQ), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_stall(rsp_stall),
    .rsp_stall_id(rsp_stall_id), .wake_vec(wake_vec));

  int n_chk = 0, n_fail = 0;

  function automatic logic [63:0] ctl(int c, bit t, bit f, bit e);
    return (64'd3 << 28) | (64'(c) << 18) | (64'd1 << 17) |
           (64'(t) << 16) | (64'(f) << 1) | 64'(e);
  endfunction

  typedef struct packed {
    logic        wr;
    logic [3:0]  view;
    logic [63:0] wd;
    logic [2:0]  id;
    logic        stall;
    logic        chk_rd;
    logic [63:0] rd;
    logic [7:0]  wake;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd1, 64'h0,  3'd0, 1'b0, 1'b1, ctl(0,0,0,1), 8'h00},  // R2 R10 reset tag
    '{1'b0, 4'd3, 64'h0,  3'd0, 1'b0, 1'b1, 64'h0,        8'h00},  // R4 try read empty
    '{1'b0, 4'd2, 64'h0,  3'd3, 1'b1, 1'b1, 64'h0,        8'h00},  // R5 park id 3
    '{1'b1, 4'd3, 64'hA1, 3'd0, 1'b0, 1'b0, 64'h0,        8'h08},  // R3 R7 push wakes
    '{1'b1, 4'd3, 64'hA2, 3'd1, 1'b0, 1'b0, 64'h0,        8'h00},  // R3
    '{1'b0, 4'd0, 64'h0,  3'd0, 1'b0, 1'b1, 64'hA1,       8'h00},  // R8 bypass head
    '{1'b1, 4'd0, 64'hB2, 3'd0, 1'b0, 1'b0, 64'h0,        8'h00},  // R8 patch newest
    '{1'b0, 4'd1, 64'h0,  3'd0, 1'b0, 1'b1, ctl(2,0,0,0), 8'h00},  // R10 count 2
    '{1'b0, 4'd2, 64'h0,  3'd2, 1'b0, 1'b1, 64'hA1,       8'h00},  // R4 pop
    '{1'b0, 4'd3, 64'h0,  3'd2, 1'b0, 1'b1, 64'hB2,       8'h00},  // R4 R8 patched
    '{1'b0, 4'd4, 64'h0,  3'd0, 1'b0, 1'b1, 64'h0,        8'h00},  // R11 sem view
    '{1'b0, 4'd9, 64'h0,  3'd0, 1'b0, 1'b1, '1,           8'h00},  // R11 unused view
    '{1'b0, 4'd1, 64'h0,  3'd0, 1'b0, 1'b1, ctl(0,0,0,1), 8'h00}   // R1 R11 state kept
  };

  task automatic acc(input bit wr, input logic [3:0] v, input logic [63:0] wd,
                     input logic [2:0] id);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'({v, 3'b000});
    req_wdata = wd; req_id = id;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FIFO cell FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 wake at reset", 64'(wake_vec), 64'h0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      acc(VECS[i].wr, VECS[i].view, VECS[i].wd, VECS[i].id);
      chk($sformatf("R1 vec%0d valid", i), 64'(rsp_valid), 64'h1);
      chk($sformatf("R5 vec%0d stall", i), 64'(rsp_stall), 64'(VECS[i].stall));
      chk($sformatf("R7 vec%0d wake", i), 64'(wake_vec), 64'(VECS[i].wake));
      if (VECS[i].chk_rd)
        chk($sformatf("R1 vec%0d rdata", i), rsp_rdata, VECS[i].rd);
    end

    // R12 fill across the wrap point (head is at slot 2)
    for (int i = 0; i < 8; i++) acc(1, 4'd3, 64'h100 + 64'(i), 3'd0);
    acc(0, 4'd1, 0, 0);
    chk("R3 full tag", rsp_rdata, ctl(8,0,1,0));
    acc(1, 4'd2, 64'hEE, 3'd5);
    chk("R6 stall", 64'(rsp_stall), 64'h1);
    chk("R6 stall id", 64'(rsp_stall_id), 64'h5);
    acc(1, 4'd3, 64'hEF, 3'd1);
    chk("R7 R3 dropped push wakes", 64'(wake_vec), 64'h20);
    acc(1, 4'd2, 64'hF0, 3'd6);
    chk("R6 second park", 64'(rsp_stall), 64'h1);
    acc(0, 4'd3, 0, 3'd0);
    chk("R4 pop head", rsp_rdata, 64'h100);
    chk("R7 pop wakes", 64'(wake_vec), 64'h40);
    acc(0, 4'd1, 0, 0);
    chk("R4 F cleared", rsp_rdata, ctl(7,0,0,0));
    for (int i = 1; i < 8; i++) begin
      acc(0, 4'd3, 0, 3'd0);
      chk($sformatf("R12 order %0d", i), rsp_rdata, 64'h100 + 64'(i));
    end
    acc(0, 4'd1, 0, 0);
    chk("R4 E set after drain", rsp_rdata, ctl(0,0,0,1));

    // R9 control writes
    acc(1, 4'd1, 64'h1_0000, 0);
    acc(0, 4'd1, 0, 0);
    chk("R9 T set E clear", rsp_rdata, ctl(0,1,0,0));
    acc(1, 4'd3, 64'hC1, 0);
    acc(1, 4'd3, 64'hC2, 0);
    acc(1, 4'd1, 64'h1, 0);
    acc(0, 4'd1, 0, 0);
    chk("R9 E write clears count", rsp_rdata, ctl(0,0,0,1));
    acc(0, 4'd0, 0, 0);
    chk("R8 bypass head slot", rsp_rdata, 64'hC1);
    acc(1, 4'd0, 64'hDEAD, 0);
    acc(0, 4'd0, 0, 0);
    chk("R8 bypass write ignored when empty", rsp_rdata, 64'hC1);

    // R2 reset from a busy state
    acc(1, 4'd3, 64'h77, 0);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    acc(0, 4'd1, 0, 0);
    chk("R2 reset tag", rsp_rdata, ctl(0,0,0,1));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule